// File: doc/BRIEF.md
# Data-Ready and Readout Buffer Controller

This block sits between a converter core and the read path of an SPI target. The core reports each finished conversion with a one-cycle strobe and a result word. The block keeps the newest result together with a 4-bit conversion sequence number. It copies that pair into the output shift register when a frame begins. It also drives an active-low data-ready line that tells the host whether unread data is waiting.

A conversion-data read consumes the result at its eighth SCLK falling edge, and data-ready then returns high. A frame that ends earlier leaves the result unread, and it may be read again any number of times. A result that finishes while a frame is shifting is parked in the holding register. It is shown in the next frame, and data-ready stays low for it. When data-ready is already low as a new result lands, the line is pulsed high for a parameter-set number of clock cycles, so the host sees a fresh falling edge. A stop request made during a frame halts conversions once that frame closes. The last result stays readable, and data-ready is left as it was.

All SPI-side inputs (chip select, SCLK falling-edge strobe, read-frame flag, stop request) are assumed to be already synchronous to the system clock.

Top module: `drdy_ctrl`

## Requirements
- R1: After reset, drdy_n is 1, conv_count is 0, sdo_load is 0 and conv_enable is 1.
- R2: An accepted result (conv_done high while conv_enable is 1) arriving when drdy_n is high drives drdy_n low in the next cycle.
- R3: An accepted result arriving while a result is still unread drives drdy_n high for exactly PULSE_CYC cycles, after which it goes low again.
- R4: In a frame with rd_frame=1, the CLR_EDGE-th (default 8th) sclk_fall strobe marks the result as read, and drdy_n is high from the next cycle. A frame with rd_frame=0 never clears it.
- R5: If cs_n rises before the CLR_EDGE-th sclk_fall, drdy_n stays low.
- R6: One cycle after cs_n is sampled falling, sdo_load is 1 for one cycle, and sdo_word/sdo_count hold the newest result and its sequence number.
- R7: A result accepted while cs_n is low does not change sdo_word during that frame. It stops that frame from clearing data-ready, and the next frame loads it.
- R8: Reading again without a newer conversion returns the same sdo_word and sdo_count.
- R9: conv_count advances by one per accepted result and wraps from 15 to 0. sdo_count equals the conv_count value reached by the result being shown.
- R10: A result not read before the next one is accepted is lost: the next frame shows only the newer word, and its count is higher by the number of accepted results.
- R11: A stop_req pulse during a frame clears conv_enable one cycle after cs_n is sampled rising. Results that arrive after that leave conv_count, drdy_n and the readable word unchanged, and drdy_n is not forced high by the stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a conversion result is ready |
| conv_data | input | DATA_W | Result word that comes with conv_done |
| cs_n | input | 1 | SPI chip select, active low, synchronised |
| sclk_fall | input | 1 | One-cycle strobe per SCLK falling edge |
| rd_frame | input | 1 | Current frame reads conversion data |
| stop_req | input | 1 | Stop command written in the current frame |
| drdy_n | output | 1 | Data-ready, active low |
| conv_enable | output | 1 | Conversions allowed; low after a stop |
| sdo_load | output | 1 | One-cycle load pulse for the output shifter |
| sdo_word | output | DATA_W | Word presented to the output shifter |
| sdo_count | output | 4 | Sequence number of the presented word |
| conv_count | output | 4 | Running conversion counter |

## Verification
Full reads and short reads are tried, and they tell a consumed result from an unread one on drdy_n. Back-to-back results are used as well, and they separate the high-pulse path from the plain falling edge and show overwriting through count jumps. Results that arrive mid-frame before and after the clearing edge show that the parked word is neither shown early nor cleared too soon. A constrained-random mix of results, full, short and non-read frames is checked against a bench model of the counter, newest word and unread flag. A stop sequence at the end shows conversions halting while the old word stays readable.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
    localparam int CNT_W = 4;

    typedef struct packed {
        logic             unread;
        logic             newer;
        logic             run;
        logic             stop_pend;
        logic             cs_q;
        logic             load;
        logic [CNT_W-1:0] cnt;
    } ctl_t;
endpackage

// File: rtl/drdy_pulse.sv
module drdy_pulse #(
    parameter int PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);
    localparam int TW = $clog2(PULSE_CYC + 1);

    logic [TW-1:0] tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (fire)
            tmr_d = TW'(PULSE_CYC);
        else if (tmr_q != '0)
            tmr_d = tmr_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign active = (tmr_q != '0);

    p_pulse_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> active);
    p_pulse_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q <= TW'(PULSE_CYC));
endmodule

// File: rtl/frame_edge_cnt.sv
module frame_edge_cnt #(
    parameter int CLR_EDGE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic frame_start,
    input  logic sclk_fall,
    output logic hit
);
    localparam int CW = $clog2(CLR_EDGE + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] eff;

    always_comb begin
        eff   = frame_start ? '0 : cnt_q;
        cnt_d = eff;
        if (!cs_n && sclk_fall && eff < CW'(CLR_EDGE))
            cnt_d = eff + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = !cs_n && sclk_fall && (eff == CW'(CLR_EDGE - 1));

    p_edge_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(CLR_EDGE));
endmodule

// File: rtl/drdy_ctrl.sv
module drdy_ctrl
    import drdy_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int PULSE_CYC = 4,
    parameter int CLR_EDGE  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              cs_n,
    input  logic              sclk_fall,
    input  logic              rd_frame,
    input  logic              stop_req,
    output logic              drdy_n,
    output logic              conv_enable,
    output logic              sdo_load,
    output logic [DATA_W-1:0] sdo_word,
    output logic [CNT_W-1:0]  sdo_count,
    output logic [CNT_W-1:0]  conv_count
);
    ctl_t              ctl_d, ctl_q;
    logic [DATA_W-1:0] lat_word_d, lat_word_q, sdo_word_d, sdo_word_q;
    logic [CNT_W-1:0]  lat_cnt_d, lat_cnt_q, sdo_cnt_d, sdo_cnt_q;

    logic accept, start, fin, edge_hit, clr, pulse_on;

    assign accept = conv_done && ctl_q.run;
    assign start  = ctl_q.cs_q && !cs_n;
    assign fin    = !ctl_q.cs_q && cs_n;

    frame_edge_cnt #(.CLR_EDGE(CLR_EDGE)) u_edges (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .frame_start (start),
        .sclk_fall   (sclk_fall),
        .hit         (edge_hit)
    );

    drdy_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (accept && ctl_q.unread),
        .active (pulse_on)
    );

    // a read only consumes the result if nothing newer arrived since its load
    assign clr = edge_hit && rd_frame && !ctl_q.newer && !accept;

    always_comb begin
        ctl_d      = ctl_q;
        lat_word_d = lat_word_q;
        lat_cnt_d  = lat_cnt_q;
        sdo_word_d = sdo_word_q;
        sdo_cnt_d  = sdo_cnt_q;

        ctl_d.cs_q   = cs_n;
        ctl_d.load   = start;
        ctl_d.unread = accept || (ctl_q.unread && !clr);
        ctl_d.newer  = (accept && !cs_n) || (ctl_q.newer && !start);

        if (accept) begin
            ctl_d.cnt  = ctl_q.cnt + 1'b1;
            lat_word_d = conv_data;
            lat_cnt_d  = ctl_q.cnt + 1'b1;
        end

        if (start) begin
            sdo_word_d = lat_word_q;
            sdo_cnt_d  = lat_cnt_q;
        end

        if (stop_req && !cs_n)
            ctl_d.stop_pend = 1'b1;
        if (fin) begin
            ctl_d.stop_pend = 1'b0;
            if (ctl_q.stop_pend || (stop_req && !cs_n))
                ctl_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '{unread: 1'b0, newer: 1'b0, run: 1'b1, stop_pend: 1'b0,
                            cs_q: 1'b1, load: 1'b0, cnt: '0};
            lat_word_q <= '0;
            lat_cnt_q  <= '0;
            sdo_word_q <= '0;
            sdo_cnt_q  <= '0;
        end else begin
            ctl_q      <= ctl_d;
            lat_word_q <= lat_word_d;
            lat_cnt_q  <= lat_cnt_d;
            sdo_word_q <= sdo_word_d;
            sdo_cnt_q  <= sdo_cnt_d;
        end
    end

    assign drdy_n      = !ctl_q.unread || pulse_on;
    assign conv_enable = ctl_q.run;
    assign sdo_load    = ctl_q.load;
    assign sdo_word    = sdo_word_q;
    assign sdo_count   = sdo_cnt_q;
    assign conv_count  = ctl_q.cnt;

    p_fresh_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !ctl_q.unread) |=> !drdy_n);
    p_load_after_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_load |-> ($past(!cs_n) && !$past(sdo_load)));
    p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_load |-> $stable(sdo_word));
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> conv_count == $past(conv_count) + 4'd1);
    p_stop_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_enable |=> !conv_enable);
    p_stop_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_enable && conv_done) |=> $stable(conv_count));
endmodule

// File: tb/drdy_ctrl_test.sv
module drdy_ctrl_test;
    localparam int DW  = 24;
    localparam int PW  = 4;
    localparam int CLR = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_done = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic          cs_n = 1'b1;
    logic          sclk_fall = 1'b0;
    logic          rd_frame = 1'b0;
    logic          stop_req = 1'b0;
    logic          drdy_n, conv_enable, sdo_load;
    logic [DW-1:0] sdo_word;
    logic [3:0]    sdo_count, conv_count;

    drdy_ctrl #(.DATA_W(DW), .PULSE_CYC(PW), .CLR_EDGE(CLR)) uut (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
        .cs_n(cs_n), .sclk_fall(sclk_fall), .rd_frame(rd_frame), .stop_req(stop_req),
        .drdy_n(drdy_n), .conv_enable(conv_enable), .sdo_load(sdo_load),
        .sdo_word(sdo_word), .sdo_count(sdo_count), .conv_count(conv_count)
    );

    always #4 clk = ~clk;

    int total = 0, fails = 0;
    bit done = 0;

    // bench model
    logic [3:0]    m_cnt = 0, m_lat_cnt = 0;
    logic [DW-1:0] m_lat = 0;
    bit            m_unread = 0, m_newer = 0, m_run = 1, m_in_frame = 0;

    function automatic logic [3:0] next_cnt(input logic [3:0] c);
        return (c == 4'd15) ? 4'd0 : c + 4'd1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic model_accept(input logic [DW-1:0] d);
        if (m_run) begin
            m_cnt     = next_cnt(m_cnt);
            m_lat     = d;
            m_lat_cnt = m_cnt;
            m_unread  = 1;
            if (m_in_frame) m_newer = 1;
        end
    endtask

    task automatic conv(input logic [DW-1:0] d);
        conv_done = 1'b1;
        conv_data = d;
        @(negedge clk);
        conv_done = 1'b0;
        model_accept(d);
        chk(conv_count == m_cnt, "R9 count", conv_count, m_cnt);
    endtask

    task automatic frame(input int nedges, input bit rd, input int conv_at,
                         input logic [DW-1:0] cd, input bit do_stop, input string req);
        logic [DW-1:0] w0;
        cs_n = 1'b0;
        rd_frame = rd;
        @(negedge clk);
        m_in_frame = 1; m_newer = 0;
        chk(sdo_load == 1'b1, "R6 load pulse", sdo_load, 1);
        chk(sdo_word == m_lat, "R6 word", sdo_word, m_lat);
        chk(sdo_count == m_lat_cnt, "R6 count", sdo_count, m_lat_cnt);
        w0 = sdo_word;
        for (int e = 0; e < nedges; e++) begin
            if (e == conv_at) conv(cd);
            sclk_fall = 1'b1;
            stop_req = (do_stop && e == 0);
            @(negedge clk);
            sclk_fall = 1'b0;
            stop_req = 1'b0;
            if (e == CLR - 1 && rd && !m_newer) m_unread = 0;
            @(negedge clk);
        end
        chk(sdo_word == w0, "R7 word held in frame", sdo_word, w0);
        cs_n = 1'b1;
        rd_frame = 1'b0;
        m_in_frame = 0;
        @(negedge clk);
        if (do_stop) m_run = 0;
        idle(PW + 1);
        chk(drdy_n == !m_unread, req, drdy_n, !m_unread);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        m_cnt = 0; m_lat = 0; m_lat_cnt = 0; m_unread = 0; m_run = 1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int hi;
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk(drdy_n == 1'b1, "R1 drdy_n", drdy_n, 1);
        chk(conv_count == 4'd0, "R1 count", conv_count, 0);
        chk(sdo_load == 1'b0, "R1 sdo_load", sdo_load, 0);
        chk(conv_enable == 1'b1, "R1 enable", conv_enable, 1);

        // R2 fresh result drops data-ready next cycle
        conv(24'h111111);
        chk(drdy_n == 1'b0, "R2 drdy low", drdy_n, 0);

        // R3 result while unread: high pulse of PW cycles
        conv(24'h222222);
        hi = 0;
        while (drdy_n && hi < 20) begin hi++; @(negedge clk); end
        chk(hi == PW, "R3 pulse width", hi, PW);
        chk(drdy_n == 1'b0, "R3 low after pulse", drdy_n, 0);

        // R10 overwrite: 0x111111 lost, count jumped by 2
        frame(CLR, 1, -1, '0, 0, "R4 full read clears");
        chk(sdo_word == 24'h222222 && sdo_count == 4'd2, "R10 newest only", sdo_word, 24'h222222);

        // R5 short read keeps unread
        conv(24'h333333);
        frame(5, 1, -1, '0, 0, "R5 short read keeps low");
        // R4 non-read frame does not clear
        frame(CLR, 0, -1, '0, 0, "R4 non-read frame keeps low");
        // R8 repeated read returns same word
        frame(CLR, 1, -1, '0, 0, "R8 repeat read");
        frame(3, 1, -1, '0, 0, "R8 reread after consume");
        chk(sdo_word == 24'h333333 && sdo_count == 4'd3, "R8 same word", sdo_word, 24'h333333);

        // R7 result during read, before and after the clearing edge
        conv(24'h444444);
        frame(CLR, 1, 3, 24'h555555, 0, "R7 parked keeps low (early)");
        frame(2, 1, -1, '0, 0, "R7 parked result loaded");
        chk(sdo_word == 24'h555555, "R7 next frame word", sdo_word, 24'h555555);
        frame(CLR, 1, -1, '0, 0, "R4 clear");
        conv(24'h666666);
        frame(CLR + 2, 1, CLR + 1, 24'h777777, 0, "R7 late arrival keeps low");

        // R9 wrap
        for (int i = 0; i < 20; i++) conv(DW'(i * 7 + 1));
        idle(PW + 1);
        frame(CLR, 1, -1, '0, 0, "R9 read after wrap");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 4) begin
                conv(DW'($urandom));
                idle(PW + 1);
                chk(drdy_n == !m_unread, "R2 random drdy", drdy_n, !m_unread);
            end else if (op < 7) begin
                frame(CLR, 1, (op == 6) ? int'($urandom_range(0, CLR)) : -1,
                      DW'($urandom), 0, "R4 random full read");
            end else if (op < 9) begin
                frame(int'($urandom_range(0, CLR - 1)), 1, -1, '0, 0, "R5 random short read");
            end else begin
                frame(CLR, 0, -1, '0, 0, "R4 random non-read");
            end
        end

        // R11 stop
        conv(24'hABCDEF);
        idle(PW + 1);
        frame(3, 0, 1, 24'hBEEF01, 1, "R11 not forced high");
        chk(conv_enable == 1'b0, "R11 enable low", conv_enable, 0);
        conv(24'h999999);
        idle(PW + 1);
        chk(drdy_n == 1'b0, "R11 drdy unchanged", drdy_n, 0);
        frame(2, 1, -1, '0, 0, "R11 still unread");
        chk(sdo_word == 24'hBEEF01, "R11 last word readable", sdo_word, 24'hBEEF01);

        done = 1;
        summary();
        $finish;
    end
endmodule